// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block moves an SDRAM device into and out of power-down. A two-bit low-power mode field selects the function. When the field holds binary 10 and the arbiter reports that no access is pending, the block drops CKE. The device does nothing during power-down and so does not refresh itself. When the external refresh timer raises its due flag, the block therefore brings the device out and issues the refresh command itself. It then lowers CKE again if the memory is still idle.

The wake-up sequence depends on the memory family. SDR and low-power SDR parts receive a single NOP after CKE rises. Low-power DDR1 parts receive NOPs for a programmable TXP count. Low-power DDR1 and DDR2 parts must also keep CKE low for a programmable TCKE count before any exit may start, even when a request arrives earlier. The same exit rules apply when software moves the mode field away from 10 while the device is powered down. Outside this sequence the command output stays at deselect, so the normal command path owns the bus.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: After reset, `cke` is 1, `cmd` is deselect (2'b00) and `pd_active` is 0.
- R2: Power-down starts, with `cke` low in the cycle after the sampling edge, only when `lp_mode` is 2'b10 and both `req_pending` and `refresh_due` are 0. While a request is pending, `cke` stays high.
- R3: With `lp_mode` at 2'b00, 2'b01 or 2'b11, `cke` never goes low and `cmd` stays deselect.
- R4: While `cke` is low, `cmd` is deselect.
- R5: For `mem_kind` 2'b10 (low-power DDR1) and 2'b11 (DDR2), `cke` stays low for max(`tcke_cycles`,1) cycles or longer, even when an exit cause is present from the first power-down cycle.
- R6: For `mem_kind` 2'b00 (SDR), 2'b01 (low-power SDR) and 2'b11, exactly one NOP (2'b01) cycle with `cke` high follows power-down, before any other command.
- R7: For `mem_kind` 2'b10, NOP is driven with `cke` high for exactly max(`txp_cycles`,1) cycles after `cke` rises.
- R8: If `refresh_due` is high when the wake-up NOPs end, one refresh cycle (`cmd` 2'b10) follows. The block then returns to normal for one cycle and powers down again if the memory is still idle.
- R9: If `lp_mode` leaves 2'b10 during power-down, the device exits under the same residency and NOP rules, and afterwards it does not enter power-down again.
- R10: `pd_active` is 1 exactly in the cycles where `cke` is low.
- R11: For `mem_kind` 2'b00 and 2'b01, `tcke_cycles` has no effect. A request present in the first power-down cycle gives exactly one low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_mode | input | 2 | Low-power mode field; 2'b10 enables power-down |
| mem_kind | input | 2 | 00 SDR, 01 LP-SDR, 10 LP-DDR1, 11 DDR2 |
| req_pending | input | 1 | Arbiter has an access waiting |
| refresh_due | input | 1 | Refresh timer demands a refresh |
| txp_cycles | input | CW | NOP cycles after wake for LP-DDR1 |
| tcke_cycles | input | CW | Minimum low-CKE residency for DDR kinds |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 2 | 00 deselect, 01 NOP, 10 refresh |
| pd_active | output | 1 | Power-down in effect |

## Verification
Some rules are checked on every cycle. Deselect is held while `cke` is low. A falling `cke` must have been preceded by mode 10 with the memory idle. A NOP must be the first command after `cke` rises. A refresh must come straight after a NOP. For the DDR kinds, the number of low cycles is counted and compared with `tcke_cycles` on every exit. Other results need the bench's scenarios, which compare against computed values. These are the exact NOP count for each memory kind, the exact low-cycle count when a request arrives early or late, re-entry after a refresh, no re-entry after a mode change, and the fact that `tcke_cycles` is ignored for SDR kinds.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;
  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_NOP   = 2'b01,
    CMD_REF   = 2'b10
  } cmd_e;

  typedef enum logic [1:0] {
    KIND_SDR    = 2'b00,
    KIND_LPSDR  = 2'b01,
    KIND_LPDDR1 = 2'b10,
    KIND_DDR2   = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_PD,
    ST_WAKE,
    ST_REF
  } state_e;

  localparam logic [1:0] LP_MODE_PD = 2'b10;

  // DDR-class kinds share bit 1 of the kind code
  function automatic logic kind_is_ddr(input logic [1:0] k);
    return k[1];
  endfunction
endpackage

// File: rtl/pd_cnt.sv
// Loadable saturating down-counter
module pd_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pd_exit_sel.sv
// Per-kind timing: residency and wake NOP counts, minus one
module pd_exit_sel
  import sdram_pd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   mem_kind,
  input  logic [W-1:0] txp_cycles,
  input  logic [W-1:0] tcke_cycles,
  output logic [W-1:0] res_load,
  output logic [W-1:0] nop_load
);
  always_comb begin
    res_load = '0;
    if (kind_is_ddr(mem_kind) && (tcke_cycles != '0)) begin
      res_load = tcke_cycles - 1'b1;
    end
    nop_load = '0;
    if ((mem_kind == KIND_LPDDR1) && (txp_cycles != '0)) begin
      nop_load = txp_cycles - 1'b1;
    end
  end
endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
  import sdram_pd_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    lp_mode,
  input  logic [1:0]    mem_kind,
  input  logic          req_pending,
  input  logic          refresh_due,
  input  logic [CW-1:0] txp_cycles,
  input  logic [CW-1:0] tcke_cycles,
  output logic          cke,
  output logic [1:0]    cmd,
  output logic          pd_active
);
  state_e state_q, state_d;
  logic [CW-1:0] res_load, nop_load;
  logic res_zero, nop_zero;
  logic go_pd, want_exit;
  logic res_ld, nop_ld;
  cmd_e cmd_d;

  assign go_pd     = (lp_mode == LP_MODE_PD) && !req_pending && !refresh_due;
  assign want_exit = req_pending || refresh_due || (lp_mode != LP_MODE_PD);

  pd_exit_sel #(.W(CW)) u_sel (
    .mem_kind    (mem_kind),
    .txp_cycles  (txp_cycles),
    .tcke_cycles (tcke_cycles),
    .res_load    (res_load),
    .nop_load    (nop_load)
  );

  assign res_ld = (state_q == ST_RUN) && go_pd;
  assign nop_ld = (state_q == ST_PD) && want_exit && res_zero;

  pd_cnt #(.W(CW)) u_res (
    .clk      (clk),
    .rst      (rst),
    .load     (res_ld),
    .load_val (res_load),
    .dec      (state_q == ST_PD),
    .zero     (res_zero)
  );

  pd_cnt #(.W(CW)) u_nop (
    .clk      (clk),
    .rst      (rst),
    .load     (nop_ld),
    .load_val (nop_load),
    .dec      (state_q == ST_WAKE),
    .zero     (nop_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (go_pd) state_d = ST_PD;
      ST_PD:   if (want_exit && res_zero) state_d = ST_WAKE;
      ST_WAKE: if (nop_zero) state_d = refresh_due ? ST_REF : ST_RUN;
      ST_REF:  state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_WAKE: cmd_d = CMD_NOP;
      ST_REF:  cmd_d = CMD_REF;
      default: cmd_d = CMD_DESEL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_RUN;
      cke       <= 1'b1;
      cmd       <= CMD_DESEL;
      pd_active <= 1'b0;
    end else begin
      state_q   <= state_d;
      cke       <= (state_d != ST_PD);
      cmd       <= cmd_d;
      pd_active <= (state_d == ST_PD);
    end
  end
endmodule

// File: rtl/sdram_pd_chk.sv
module sdram_pd_chk
  import sdram_pd_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    lp_mode,
  input logic [1:0]    mem_kind,
  input logic          req_pending,
  input logic          refresh_due,
  input logic [CW-1:0] tcke_cycles,
  input logic          cke,
  input logic [1:0]    cmd
);
  localparam int LW = CW + 1;
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || cke) begin
      low_cnt <= '0;
    end else if (low_cnt != {LW{1'b1}}) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  p_entry_idle_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> ($past(lp_mode) == LP_MODE_PD) && !$past(req_pending) && !$past(refresh_due));

  p_desel_low_r4: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (cmd == CMD_DESEL));

  p_first_nop_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (cmd == CMD_NOP));

  p_ref_after_nop_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |-> cke && ($past(cmd) == CMD_NOP));

  p_residency_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(cke) && kind_is_ddr(mem_kind)) |-> (low_cnt >= {1'b0, tcke_cycles}) && (low_cnt != '0));
endmodule

bind sdram_pd_ctrl sdram_pd_chk #(.CW(CW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .lp_mode     (lp_mode),
  .mem_kind    (mem_kind),
  .req_pending (req_pending),
  .refresh_due (refresh_due),
  .tcke_cycles (tcke_cycles),
  .cke         (cke),
  .cmd         (cmd)
);

// File: tb/sim_sdram_pd_ctrl.sv
module sim_sdram_pd_ctrl;
  localparam int CW = 8;
  localparam logic [1:0] C_DESEL = 2'b00, C_NOP = 2'b01, C_REF = 2'b10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] lp_mode = 2'b00;
  logic [1:0] mem_kind = 2'b00;
  logic req_pending = 1'b0;
  logic refresh_due = 1'b0;
  logic [CW-1:0] txp_cycles = '0;
  logic [CW-1:0] tcke_cycles = '0;
  logic cke;
  logic [1:0] cmd;
  logic pd_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_pd_ctrl #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .lp_mode(lp_mode), .mem_kind(mem_kind),
    .req_pending(req_pending), .refresh_due(refresh_due),
    .txp_cycles(txp_cycles), .tcke_cycles(tcke_cycles),
    .cke(cke), .cmd(cmd), .pd_active(pd_active)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_low(input logic [1:0] kind, input int tcke, input int k);
    int lmin = (kind[1] && tcke > 1) ? tcke : 1;
    return (k + 1 > lmin) ? k + 1 : lmin;
  endfunction

  function automatic int exp_nops(input logic [1:0] kind, input int txp);
    if (kind == 2'b10) return (txp > 1) ? txp : 1;
    return 1;
  endfunction

  // R10 on every observed cycle
  always @(negedge clk) begin
    if (!rst && !done) check(pd_active == !cke, "R10 status", pd_active, !cke);
  end

  // Enter power-down, raise an exit cause after k low cycles, measure exit
  task automatic run_case(input logic [1:0] kind, input int txp, input int tcke,
                          input int k, input bit use_ref);
    int low, nops, guard;
    @(negedge clk);
    mem_kind = kind; txp_cycles = CW'(txp); tcke_cycles = CW'(tcke);
    lp_mode = 2'b10; req_pending = 0; refresh_due = 0;
    @(negedge clk);
    check(cke == 0, "R2 entry", cke, 0);
    if (cke != 0) return;
    check(cmd == C_DESEL, "R4 desel", cmd, C_DESEL);
    low = 1;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (cke == 0) low++;
    end
    if (use_ref) refresh_due = 1; else req_pending = 1;
    @(negedge clk);
    while (cke == 0 && low < 300) begin low++; @(negedge clk); end
    check(low == exp_low(kind, tcke, k), kind[1] ? "R5 residency" : "R11 residency", low, exp_low(kind, tcke, k));
    nops = 0;
    while (cke == 1 && cmd == C_NOP && nops < 300) begin nops++; @(negedge clk); end
    check(nops == exp_nops(kind, txp), (kind == 2'b10) ? "R7 nops" : "R6 nops", nops, exp_nops(kind, txp));
    if (use_ref) begin
      check(cmd == C_REF && cke == 1, "R8 refresh", cmd, C_REF);
      refresh_due = 0;
      @(negedge clk);
      check(cmd == C_DESEL && cke == 1, "R8 normal", cmd, C_DESEL);
      @(negedge clk);
      check(cke == 0, "R8 reenter", cke, 0);
      req_pending = 1;
      guard = 0;
      while (!(cke == 1 && cmd == C_DESEL) && guard < 300) begin guard++; @(negedge clk); end
      check(guard < 300, "R8 exit", guard, 0);
    end else begin
      check(cmd == C_DESEL && cke == 1, "R6 after wake", cmd, C_DESEL);
      @(negedge clk);
      check(cke == 1, "R2 busy", cke, 1);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check(cke == 1 && cmd == C_DESEL && pd_active == 0, "R1 reset", {cke, cmd, pd_active}, 4'b1000);
    rst = 0;
    @(negedge clk);
    check(cke == 1 && cmd == C_DESEL && pd_active == 0, "R1 after reset", {cke, cmd, pd_active}, 4'b1000);

    // R3: other mode values never power down
    foreach (lp_mode[i]) ;
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      lp_mode = 2'(m);
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        check(cke == 1 && cmd == C_DESEL, "R3 no pd", cke, 1);
      end
    end

    // Directed corners
    run_case(2'b00, 0, 9, 0, 0);   // R11 tcke ignored, SDR
    run_case(2'b01, 5, 9, 0, 0);   // R11 LP-SDR, txp ignored
    run_case(2'b11, 0, 6, 0, 0);   // R5 early request, DDR2
    run_case(2'b10, 4, 3, 0, 0);   // R7 LP-DDR1 txp=4
    run_case(2'b10, 0, 0, 2, 0);   // R7 txp=0 -> one NOP
    run_case(2'b11, 3, 2, 7, 1);   // R8 refresh with late cause
    run_case(2'b00, 0, 0, 0, 1);   // R8 SDR refresh

    // R9: mode leaves 10 during power-down
    begin
      int low, nops;
      @(negedge clk);
      mem_kind = 2'b10; txp_cycles = 3; tcke_cycles = 4; req_pending = 0; lp_mode = 2'b10;
      @(negedge clk);
      check(cke == 0, "R9 entry", cke, 0);
      lp_mode = 2'b00;
      low = 1; @(negedge clk);
      while (cke == 0 && low < 300) begin low++; @(negedge clk); end
      check(low == 4, "R9 residency", low, 4);
      nops = 0;
      while (cke == 1 && cmd == C_NOP && nops < 300) begin nops++; @(negedge clk); end
      check(nops == 3, "R9 nops", nops, 3);
      for (int c = 0; c < 5; c++) begin
        check(cke == 1 && cmd == C_DESEL, "R9 stay awake", cke, 1);
        @(negedge clk);
      end
    end

    // Constrained random
    for (int it = 0; it < 40; it++) begin
      logic [1:0] kind = 2'($urandom_range(0, 3));
      int txp = $urandom_range(0, 7);
      int tcke = $urandom_range(0, 9);
      int k = $urandom_range(0, 12);
      bit use_ref = 1'($urandom_range(0, 1));
      run_case(kind, txp, tcke, k, use_ref);
    end

    lp_mode = 2'b00;
    req_pending = 0;
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule